// File: doc/BRIEF.md
# Remote Terminal Control and Status Register Pair

This block holds the host-visible registers of a serial-bus remote terminal. A 13-bit control register, which the host can only write, configures the terminal. It enables the two bus channels, supplies the flag values carried in the outgoing status word, turns on broadcast recognition, picks the subaddress decode mode and the self-test channel, and selects the behaviour of the busy-alert timing and of the disconnect pin. A 16-bit status register, which the host can only read, reports what the protocol engine has seen. No address bus selects between the two: a register strobe together with chip-select, read-not-write and output-enable picks the access. Each access completes in the clock cycle in which the strobes are valid.

While master reset is held, the block captures the 5-bit terminal address and its parity pin, and it holds them until the next master reset. It checks that the six bits contain an odd number of ones. A wrong parity shuts off both channels and raises the message-error flags. Event inputs from the protocol engine set sticky status bits, and those bits are cleared by a status read. The flag values for the status word are copied from the control register only on a status-word latch event. The engine therefore always transmits a coherent set of flags.

All ports are plain level or pulse signals sampled on the rising clock edge. No stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `term_regs`

## Requirements
- R1: After master reset the control register holds 0x1E0B. Every control-driven output reflects that value: channels A and B enabled, broadcast on, decode mode 1, disconnect function selected, long alert selected, self-test off, self-test channel B. The latched status-word flags are terminal flag 0, busy 1, subsystem 0, service request 0 and instrumentation 0.
- R2: A control write happens when host_cs=1, host_reg=1, host_rnw=0 and host_oe=0 in the same cycle. It loads host_wdata[12:0], and the outputs show the new value after that clock edge. Any other combination of strobes leaves the control register unchanged.
- R3: host_rdata carries the status word while host_cs=1, host_reg=1, host_rnw=1 and host_oe=1, and it is 0 otherwise. The status word reads 0x07C0 after a reset with correct parity. Its bit layout is: [4:0] mode code or subaddress, [5] 1 for a subaddress, [6] last command on channel A, [7] channel B enabled, [8] channel A enabled, [9] terminal flag enabled, [10] busy, [11] self-test, [12] address parity error, [13] message error, [14] valid message, [15] terminal active.
- R4: Status bit 14 is set by an ev_valid pulse and stays set until a status read. A read clears it, except when ev_valid arrives in the same cycle as the read, in which case the bit stays set.
- R5: Status bit 13 is set by an ev_merr pulse. A status read clears it only when ev_err_active is 0 and there is no parity error. An ev_merr in the same cycle as the read keeps the bit set.
- R6: If the terminal address plus parity pin have an even number of ones, the block sets status bits 12 and 13 and forces status bits 7 and 8 and both channel-enable outputs to 0. It also asserts merr_out from reset onward. merr_out is set by ev_merr and released by the next ev_cmd that carries no new error.
- R7: The address and parity pins are sampled only while rst_n is low. Changes on those pins after reset do not alter the parity status or the disconnect output.
- R8: When control bit 11 is 1, disc_tact_out is 1 exactly when the latched address is 5'h1F and the latched parity is 1. When control bit 11 is 0, disc_tact_out follows ev_term_active.
- R9: ev_tf_inhibit clears status bit 9, which then forces the latched terminal flag to 0. ev_tf_override sets bit 9 again without setting the flag. If both arrive in the same cycle, the inhibit wins.
- R10: sw_tflag, sw_busy, sw_subsys, sw_srq and sw_instr change only on a sw_latch cycle. At that edge they take the control value held before the edge, so a control write in the latch cycle appears at the following latch. sw_tflag is control bit 2 AND status bit 9.
- R11: An ev_cmd pulse captures ev_mcsa into status [4:0], ev_is_sa into [5] and ev_chan_a into [6]. Without ev_cmd those bits hold.
- R12: Status bit 10 (busy) follows control bit 3. It falls only through a control write that clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| ta_pins | input | 5 | Terminal address pins |
| ta_par_pin | input | 1 | Terminal address parity pin |
| host_cs | input | 1 | Host chip select |
| host_reg | input | 1 | Register strobe (register access rather than RAM) |
| host_rnw | input | 1 | 1 read, 0 write |
| host_oe | input | 1 | Output enable, must be 1 to read and 0 to write |
| host_wdata | input | 13 | Control write data |
| host_rdata | output | 16 | Status read data |
| ev_cmd | input | 1 | Valid command decoded |
| ev_chan_a | input | 1 | Command arrived on channel A |
| ev_is_sa | input | 1 | Command field is a subaddress |
| ev_mcsa | input | 5 | Mode code or subaddress of the command |
| ev_valid | input | 1 | Valid message completed |
| ev_merr | input | 1 | Message error detected |
| ev_err_active | input | 1 | Error condition still present |
| ev_tf_inhibit | input | 1 | Inhibit-terminal-flag mode code executed |
| ev_tf_override | input | 1 | Override-inhibit mode code executed |
| ev_selftest | input | 1 | Engine is in self-test |
| ev_term_active | input | 1 | Engine is transmitting or receiving |
| sw_latch | input | 1 | Status-word flag latch event |
| chan_a_en | output | 1 | Channel A enable to the engine |
| chan_b_en | output | 1 | Channel B enable to the engine |
| sw_tflag | output | 1 | Status word terminal flag |
| sw_busy | output | 1 | Status word busy |
| sw_subsys | output | 1 | Status word subsystem flag |
| sw_srq | output | 1 | Status word service request |
| sw_instr | output | 1 | Status word instrumentation |
| bcast_en | output | 1 | Broadcast recognition enable |
| notice3_sel | output | 1 | Subaddress decode mode select |
| st_en | output | 1 | Self-test enable |
| st_chan_a | output | 1 | Self-test on channel A (0 selects B) |
| long_alert | output | 1 | Long RAM-busy alert select |
| merr_out | output | 1 | Message error output |
| disc_tact_out | output | 1 | Disconnect or terminal-active output |

## Verification
The bench targets the same-cycle collisions. One is a set pulse arriving during a status read: a design that lets the clear win loses a valid-message or error report. Another is a read while the error condition persists: a design that clears anyway hides a live fault. A third is a control write in a latch cycle: a design that forwards the new value sends a status word mixing old and new flags. The bench also resets with bad parity and with the all-ones disconnect address, then moves the address pins after reset. A design that re-samples the pins, or that leaves a channel enabled under a parity error, shows it at the channel-enable and disconnect outputs.

// File: rtl/term_regs_pkg.sv
package term_regs_pkg;
  localparam int TA_W   = 5;
  localparam int CTRL_W = 13;
  localparam int STAT_W = 16;
  localparam int SWF_W  = 5;

  localparam logic [CTRL_W-1:0] CTRL_RST = 13'h1E0B;

  // control bit positions
  localparam int C_CHA   = 0;
  localparam int C_CHB   = 1;
  localparam int C_TFLAG = 2;
  localparam int C_BUSY  = 3;
  localparam int C_SUBS  = 4;
  localparam int C_STCH  = 5;
  localparam int C_STEN  = 6;
  localparam int C_SRQ   = 7;
  localparam int C_INSTR = 8;
  localparam int C_BCAST = 9;
  localparam int C_MODE  = 10;
  localparam int C_DISC  = 11;
  localparam int C_LONG  = 12;

  // status-word flags copied on a latch event
  typedef struct packed {
    logic tflag;
    logic busy;
    logic subsys;
    logic srq;
    logic instr;
  } sw_flags_t;

  localparam sw_flags_t SWF_RST = '{tflag: 1'b0, busy: 1'b1, subsys: 1'b0,
                                    srq: 1'b0, instr: 1'b0};
endpackage

// File: rtl/tr_ctl_reg.sv
module tr_ctl_reg #(
  parameter int          W   = 13,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RST;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/tr_addr_latch.sv
module tr_addr_latch #(
  parameter int TA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TA_W-1:0] pins,
  input  logic            par_pin,
  output logic [TA_W-1:0] ta,
  output logic            tpar,
  output logic            par_err,
  output logic            pin_bad
);
  // odd total of ones is correct
  assign pin_bad = ~(^{pins, par_pin});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta      <= pins;
      tpar    <= par_pin;
      par_err <= pin_bad;
    end
  end
endmodule

// File: rtl/tr_status_core.sv
module tr_status_core #(
  parameter int TA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_bad,
  input  logic            par_err,
  input  logic            rd_clr,
  input  logic            ev_cmd,
  input  logic            ev_chan_a,
  input  logic            ev_is_sa,
  input  logic [TA_W-1:0] ev_mcsa,
  input  logic            ev_valid,
  input  logic            ev_merr,
  input  logic            ev_err_active,
  input  logic            ev_tf_inhibit,
  input  logic            ev_tf_override,
  output logic            val_bit,
  output logic            merr_bit,
  output logic            merr_pin,
  output logic            tf_en,
  output logic [TA_W-1:0] cmd_mcsa,
  output logic            cmd_is_sa,
  output logic            cmd_cha
);
  localparam int NSTICKY = 2;

  // index 0: valid message, index 1: message error
  logic [NSTICKY-1:0] st_set, st_hold, st_rst, st_q;

  assign st_set  = {ev_merr, ev_valid};
  assign st_hold = {ev_err_active | par_err, 1'b0};
  assign st_rst  = {rst_bad, 1'b0};

  for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rst_n)                     st_q[i] <= st_rst[i];
      else if (st_set[i])             st_q[i] <= 1'b1;
      else if (rd_clr && !st_hold[i]) st_q[i] <= 1'b0;
    end
  end

  assign val_bit  = st_q[0];
  assign merr_bit = st_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n)       merr_pin <= rst_bad;
    else if (ev_merr) merr_pin <= 1'b1;
    else if (ev_cmd)  merr_pin <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              tf_en <= 1'b1;
    else if (ev_tf_inhibit)  tf_en <= 1'b0;
    else if (ev_tf_override) tf_en <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_mcsa  <= '0;
      cmd_is_sa <= 1'b0;
      cmd_cha   <= 1'b1;
    end else if (ev_cmd) begin
      cmd_mcsa  <= ev_mcsa;
      cmd_is_sa <= ev_is_sa;
      cmd_cha   <= ev_chan_a;
    end
  end
endmodule

// File: rtl/term_regs.sv
module term_regs
  import term_regs_pkg::*;
#(
  parameter int TA_WIDTH = TA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TA_WIDTH-1:0] ta_pins,
  input  logic                ta_par_pin,
  input  logic                host_cs,
  input  logic                host_reg,
  input  logic                host_rnw,
  input  logic                host_oe,
  input  logic [CTRL_W-1:0]   host_wdata,
  output logic [STAT_W-1:0]   host_rdata,
  input  logic                ev_cmd,
  input  logic                ev_chan_a,
  input  logic                ev_is_sa,
  input  logic [TA_WIDTH-1:0] ev_mcsa,
  input  logic                ev_valid,
  input  logic                ev_merr,
  input  logic                ev_err_active,
  input  logic                ev_tf_inhibit,
  input  logic                ev_tf_override,
  input  logic                ev_selftest,
  input  logic                ev_term_active,
  input  logic                sw_latch,
  output logic                chan_a_en,
  output logic                chan_b_en,
  output logic                sw_tflag,
  output logic                sw_busy,
  output logic                sw_subsys,
  output logic                sw_srq,
  output logic                sw_instr,
  output logic                bcast_en,
  output logic                notice3_sel,
  output logic                st_en,
  output logic                st_chan_a,
  output logic                long_alert,
  output logic                merr_out,
  output logic                disc_tact_out
);
  localparam logic [TA_WIDTH-1:0] TA_ALL1 = '1;

  logic                wr_en, rd_en;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [TA_WIDTH-1:0] ta_q;
  logic                tpar_q, par_err, pin_bad;
  logic                val_bit, merr_bit, tf_en, cmd_is_sa, cmd_cha;
  logic [TA_WIDTH-1:0] cmd_mcsa;
  logic [STAT_W-1:0]   stat_now;
  sw_flags_t           swf_q;

  assign wr_en = host_cs & host_reg & ~host_rnw & ~host_oe;
  assign rd_en = host_cs & host_reg &  host_rnw &  host_oe;

  tr_ctl_reg #(.W(CTRL_W), .RST(CTRL_RST)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .d(host_wdata), .q(ctrl_q)
  );

  tr_addr_latch #(.TA_W(TA_WIDTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .pins(ta_pins), .par_pin(ta_par_pin),
    .ta(ta_q), .tpar(tpar_q), .par_err(par_err), .pin_bad(pin_bad)
  );

  tr_status_core #(.TA_W(TA_WIDTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .rst_bad(pin_bad), .par_err(par_err),
    .rd_clr(rd_en), .ev_cmd(ev_cmd), .ev_chan_a(ev_chan_a),
    .ev_is_sa(ev_is_sa), .ev_mcsa(ev_mcsa), .ev_valid(ev_valid),
    .ev_merr(ev_merr), .ev_err_active(ev_err_active),
    .ev_tf_inhibit(ev_tf_inhibit), .ev_tf_override(ev_tf_override),
    .val_bit(val_bit), .merr_bit(merr_bit), .merr_pin(merr_out),
    .tf_en(tf_en), .cmd_mcsa(cmd_mcsa), .cmd_is_sa(cmd_is_sa),
    .cmd_cha(cmd_cha)
  );

  assign chan_a_en = ctrl_q[C_CHA] & ~par_err;
  assign chan_b_en = ctrl_q[C_CHB] & ~par_err;

  always_comb begin
    stat_now = '0;
    stat_now[TA_WIDTH-1:0] = cmd_mcsa;
    stat_now[5]  = cmd_is_sa;
    stat_now[6]  = cmd_cha;
    stat_now[7]  = chan_b_en;
    stat_now[8]  = chan_a_en;
    stat_now[9]  = tf_en;
    stat_now[10] = ctrl_q[C_BUSY];
    stat_now[11] = ev_selftest;
    stat_now[12] = par_err;
    stat_now[13] = merr_bit;
    stat_now[14] = val_bit;
    stat_now[15] = ev_term_active;
  end

  assign host_rdata = rd_en ? stat_now : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) swf_q <= SWF_RST;
    else if (sw_latch) begin
      swf_q.tflag  <= ctrl_q[C_TFLAG] & tf_en;
      swf_q.busy   <= ctrl_q[C_BUSY];
      swf_q.subsys <= ctrl_q[C_SUBS];
      swf_q.srq    <= ctrl_q[C_SRQ];
      swf_q.instr  <= ctrl_q[C_INSTR];
    end
  end

  assign sw_tflag  = swf_q.tflag;
  assign sw_busy   = swf_q.busy;
  assign sw_subsys = swf_q.subsys;
  assign sw_srq    = swf_q.srq;
  assign sw_instr  = swf_q.instr;

  assign bcast_en    = ctrl_q[C_BCAST];
  assign notice3_sel = ctrl_q[C_MODE];
  assign st_en       = ctrl_q[C_STEN];
  assign st_chan_a   = ctrl_q[C_STCH];
  assign long_alert  = ctrl_q[C_LONG];

  assign disc_tact_out = ctrl_q[C_DISC] ? ((ta_q == TA_ALL1) & tpar_q)
                                        : ev_term_active;
endmodule

// File: rtl/term_regs_chk.sv
module term_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        ev_err_active,
  input logic        ev_tf_inhibit,
  input logic        sw_latch,
  input logic [15:0] stat_now,
  input logic        chan_a_en,
  input logic        chan_b_en,
  input logic        sw_tflag,
  input logic        sw_busy,
  input logic        sw_subsys,
  input logic        sw_srq,
  input logic        sw_instr,
  input logic        bcast_en,
  input logic        notice3_sel,
  input logic        st_en,
  input logic        st_chan_a,
  input logic        long_alert
);
  assert_parity_kills_channels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_now[12] |-> (!chan_a_en && !chan_b_en));

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_now[14] && !rd_en) |=> stat_now[14]);

  assert_merr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_now[13] && (ev_err_active || stat_now[12])) |=> stat_now[13]);

  assert_ctrl_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({bcast_en, notice3_sel, st_en, st_chan_a, long_alert}));

  assert_sw_only_on_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_latch |=> $stable({sw_tflag, sw_busy, sw_subsys, sw_srq, sw_instr}));

  assert_tf_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tf_inhibit |=> !stat_now[9]);

  assert_busy_falls_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !$fell(stat_now[10]));

  assert_parity_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(stat_now[12]));
endmodule

bind term_regs term_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .ev_err_active(ev_err_active), .ev_tf_inhibit(ev_tf_inhibit),
  .sw_latch(sw_latch), .stat_now(stat_now),
  .chan_a_en(chan_a_en), .chan_b_en(chan_b_en),
  .sw_tflag(sw_tflag), .sw_busy(sw_busy), .sw_subsys(sw_subsys),
  .sw_srq(sw_srq), .sw_instr(sw_instr), .bcast_en(bcast_en),
  .notice3_sel(notice3_sel), .st_en(st_en), .st_chan_a(st_chan_a),
  .long_alert(long_alert)
);

// File: tb/sim_term_regs.sv
module sim_term_regs;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [4:0]  ta_pins;
  logic        ta_par_pin;
  logic        host_cs, host_reg, host_rnw, host_oe;
  logic [12:0] host_wdata;
  logic [15:0] host_rdata;
  logic        ev_cmd, ev_chan_a, ev_is_sa;
  logic [4:0]  ev_mcsa;
  logic        ev_valid, ev_merr, ev_err_active, ev_tf_inhibit, ev_tf_override;
  logic        ev_selftest, ev_term_active, sw_latch;
  logic        chan_a_en, chan_b_en, sw_tflag, sw_busy, sw_subsys, sw_srq, sw_instr;
  logic        bcast_en, notice3_sel, st_en, st_chan_a, long_alert, merr_out, disc_tact_out;

  term_regs u0 (.*);

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic [12:0] m_ctrl;
  logic [4:0]  m_ta, m_mcsa;
  logic        m_tpar, m_pe, m_val, m_merr, m_mout, m_tfen, m_sa, m_cha;
  logic [4:0]  m_sw; // tflag, busy, subsys, srq, instr

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s[4:0] = m_mcsa;
    s[5]   = m_sa;
    s[6]   = m_cha;
    s[7]   = m_ctrl[1] & ~m_pe;
    s[8]   = m_ctrl[0] & ~m_pe;
    s[9]   = m_tfen;
    s[10]  = m_ctrl[3];
    s[11]  = ev_selftest;
    s[12]  = m_pe;
    s[13]  = m_merr;
    s[14]  = m_val;
    s[15]  = ev_term_active;
    return s;
  endfunction

  function automatic logic [13:0] exp_outs();
    logic disc;
    disc = m_ctrl[11] ? ((m_ta == 5'h1F) & m_tpar) : ev_term_active;
    return {m_ctrl[0] & ~m_pe, m_ctrl[1] & ~m_pe, m_sw, m_ctrl[9], m_ctrl[10],
            m_ctrl[6], m_ctrl[5], m_ctrl[12], m_mout, disc};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_cs = 0; host_reg = 0; host_rnw = 0; host_oe = 0; host_wdata = '0;
    ev_cmd = 0; ev_chan_a = 0; ev_is_sa = 0; ev_mcsa = '0; ev_valid = 0;
    ev_merr = 0; ev_err_active = 0; ev_tf_inhibit = 0; ev_tf_override = 0;
    ev_selftest = 0; ev_term_active = 0; sw_latch = 0;
  endtask

  task automatic tick(input string tag);
    logic rd, wr;
    logic [12:0] n_ctrl;
    logic [4:0]  n_sw, n_mcsa;
    logic        n_val, n_merr, n_mout, n_tfen, n_sa, n_cha;
    #1;
    rd = host_cs & host_reg & host_rnw & host_oe;
    wr = host_cs & host_reg & ~host_rnw & ~host_oe;
    check({tag, " rdata"}, host_rdata, rd ? exp_status() : 16'h0);
    n_ctrl = wr ? host_wdata : m_ctrl;
    n_val  = ev_valid ? 1'b1 : (rd ? 1'b0 : m_val);
    n_merr = ev_merr ? 1'b1 : ((rd && !(ev_err_active || m_pe)) ? 1'b0 : m_merr);
    n_mout = ev_merr ? 1'b1 : (ev_cmd ? 1'b0 : m_mout);
    n_tfen = ev_tf_inhibit ? 1'b0 : (ev_tf_override ? 1'b1 : m_tfen);
    n_mcsa = ev_cmd ? ev_mcsa : m_mcsa;
    n_sa   = ev_cmd ? ev_is_sa : m_sa;
    n_cha  = ev_cmd ? ev_chan_a : m_cha;
    n_sw   = sw_latch ? {m_ctrl[2] & m_tfen, m_ctrl[3], m_ctrl[4], m_ctrl[7], m_ctrl[8]} : m_sw;
    @(posedge clk);
    m_ctrl = n_ctrl; m_val = n_val; m_merr = n_merr; m_mout = n_mout;
    m_tfen = n_tfen; m_mcsa = n_mcsa; m_sa = n_sa; m_cha = n_cha; m_sw = n_sw;
    #1;
    check({tag, " outputs"},
          {2'b00, chan_a_en, chan_b_en, sw_tflag, sw_busy, sw_subsys, sw_srq, sw_instr,
           bcast_en, notice3_sel, st_en, st_chan_a, long_alert, merr_out, disc_tact_out},
          {2'b00, exp_outs()});
  endtask

  task automatic do_reset(input logic [4:0] ta, input logic par);
    idle();
    rst_n = 0; ta_pins = ta; ta_par_pin = par;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    m_ctrl = 13'h1E0B; m_ta = ta; m_tpar = par; m_pe = ~(^{ta, par});
    m_val = 0; m_merr = m_pe; m_mout = m_pe; m_tfen = 1; m_mcsa = '0;
    m_sa = 0; m_cha = 1; m_sw = 5'b01000;
  endtask

  task automatic set_read();  idle(); host_cs = 1; host_reg = 1; host_rnw = 1; host_oe = 1; endtask
  task automatic set_write(input logic [12:0] d);
    idle(); host_cs = 1; host_reg = 1; host_wdata = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    r = $urandom(32'h5EED_1760);
    // R1 R3: reset values, good parity (00101 + 1 = three ones)
    do_reset(5'h05, 1'b1);
    set_read(); tick("R1 R3 reset");
    check("R3 reset value", exp_status(), 16'h07C0);
    // R2: strobes missing one term are ignored
    set_write(13'h0000); host_cs = 0; tick("R2 no cs");
    set_write(13'h0000); host_oe = 1; tick("R2 oe high");
    set_write(13'h0000); host_reg = 0; tick("R2 no reg strobe");
    set_write(13'h1FF4); tick("R2 write");
    set_read(); tick("R2 R12 readback");
    // R12: clear busy
    set_write(13'h0E03); tick("R12 busy clear");
    set_read(); tick("R12 busy read");
    // R11: command capture
    idle(); ev_cmd = 1; ev_chan_a = 0; ev_is_sa = 1; ev_mcsa = 5'h0B; tick("R11 cmd");
    set_read(); tick("R11 read");
    // R4: valid set, read clears; set during read wins
    idle(); ev_valid = 1; tick("R4 set");
    set_read(); ev_valid = 1; tick("R4 set during read");
    set_read(); tick("R4 read clears");
    set_read(); tick("R4 cleared");
    // R5: error held while condition present
    idle(); ev_merr = 1; tick("R5 set");
    set_read(); ev_err_active = 1; tick("R5 held");
    set_read(); tick("R5 clears");
    set_read(); tick("R5 cleared");
    // R9: inhibit and override of terminal flag
    set_write(13'h0E07); tick("R9 tflag on");
    idle(); sw_latch = 1; tick("R9 latch flag");
    idle(); ev_tf_inhibit = 1; ev_tf_override = 1; tick("R9 inhibit wins");
    idle(); sw_latch = 1; tick("R9 latch inhibited");
    idle(); ev_tf_override = 1; tick("R9 override");
    set_read(); tick("R9 read");
    // R10: write in latch cycle appears at the next latch
    set_write(13'h0198); sw_latch = 1; tick("R10 write with latch");
    idle(); tick("R10 hold");
    idle(); sw_latch = 1; tick("R10 next latch");
    // R8: terminal-active select
    set_write(13'h0003); tick("R8 select tact");
    idle(); ev_term_active = 1; tick("R8 tact high");
    idle(); tick("R8 tact low");
    // R6: bad parity reset (00100 + 1 = two ones)
    do_reset(5'h04, 1'b1);
    set_read(); tick("R6 bad parity");
    idle(); ev_cmd = 1; tick("R6 merr released");
    set_read(); tick("R6 merr bit held");
    // R8 R7: all-ones address signals disconnect; pins moved afterwards
    do_reset(5'h1F, 1'b1);
    idle(); tick("R8 disconnect");
    ta_pins = 5'h00; ta_par_pin = 1'b1;
    idle(); tick("R7 pins moved");
    set_read(); tick("R7 parity held");
    // random phase
    do_reset(5'h12, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      idle();
      r = $urandom;
      if (r[2:0] == 3'd0) begin host_cs = 1; host_reg = 1; host_wdata = $urandom; end
      else if (r[1:0] == 2'd1) begin host_cs = 1; host_reg = 1; host_rnw = 1; host_oe = 1; end
      else begin host_cs = r[8]; host_reg = r[9]; host_rnw = r[10]; host_oe = r[11];
        host_wdata = $urandom; end
      ev_cmd = (r[15:13] == 3'd0); ev_chan_a = r[16]; ev_is_sa = r[17]; ev_mcsa = r[22:18];
      ev_valid = (r[25:23] == 3'd0); ev_merr = (r[28:26] == 3'd0);
      ev_err_active = r[29]; ev_tf_inhibit = (r[31:30] == 2'd0);
      r = $urandom;
      ev_tf_override = (r[1:0] == 2'd0); ev_selftest = r[2]; ev_term_active = r[3];
      sw_latch = (r[5:4] == 2'd0);
      tick("R3 and R2 random");
    end
    idle(); tick("R3 final");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule